// File: doc/BRIEF.md
# Protected Control Register Bank

This block is the byte-wide configuration and status store for a data-converter peripheral. A simple bus drives it with an address, write data and a write strobe. Every cycle it returns the byte at the presented address, one clock later. It holds these registers:

- a control register with enable and software-reset bits;
- three configuration bytes;
- a two-byte calibration word;
- a debug control byte;
- a small interrupt-flag register.

The converter itself uses the stored fields, for example the result-resolution selector. The converter is not part of this block.

Writes pass through two separate gates. An external lock input blocks writes to every register except the interrupt flags, but a write marked as coming from a debugger ignores that lock. While the peripheral is enabled, the configuration and calibration registers refuse writes. A refused write leaves all contents unchanged and raises an error pulse on the bus response.

A software reset restores every register except the debug control byte. Flag bits are set by hardware event inputs and cleared by software writing ones.

Top module: `ctl_regbank`

## Requirements
- R1: After the synchronous reset every register reads 0x00, `bus_err` is 0, `enabled` is 0 and `res_mode` is 0.
- R2: While `wlock` is 1 and `dbg_access` is 0, a write to any offset other than 0x4 leaves the contents unchanged and pulses `bus_err` high in the cycle after the write.
- R3: A write to the flag register at offset 0x4 is never blocked by `wlock`. Its clearing takes effect and `bus_err` stays 0.
- R4: While `dbg_access` is 1, `wlock` has no effect on writes.
- R5: While the peripheral is enabled, writes to offsets 0x1 (CFGB), 0x2 (REFSEL), 0x3 (EVSEL), 0x6 and 0x7 (calibration low and high bytes) are dropped and pulse `bus_err`. Writes to offsets 0x0, 0x4 and 0x5 still take effect.
- R6: The control register is at offset 0x0. Writing it with bit 1 set to 1 enables the peripheral, and writing bit 1 as 0 disables it. Bit 1 reads back the enable state and drives `enabled`.
- R7: Writing the control register with bit 0 set to 1 restores every register except the debug byte at 0x5 to 0x00 and disables the peripheral, even if bit 1 is also set. Bit 0 then reads 1 for exactly one cycle and clears itself.
- R8: Each `evt_set` bit sets the matching flag bit (bits 2:0 at offset 0x4). Writing a 1 to a flag bit clears it. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Control bit 7 is a read-only busy bit. After any accepted write to offset 0x0 it reads 1 on the next two reads and then 0.
- R10: Reads of offsets 0x8 to 0xF return 0x00. Writes there change nothing and raise no error unless `wlock` blocks them.
- R11: `res_mode` equals bits 5:4 of CFGB: 0 selects 12-bit, 1 selects 16-bit oversampled, 2 selects 10-bit and 3 selects 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset for the read and the write |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| wlock | input | 1 | External write lock |
| dbg_access | input | 1 | Marks the current access as a debugger access |
| evt_set | input | 3 | Hardware set inputs for the flag bits |
| bus_rdata | output | 8 | Registered read data for the offset presented in the previous cycle |
| bus_err | output | 1 | Registered error pulse for a refused write |
| enabled | output | 1 | Peripheral enable state |
| res_mode | output | 2 | Selected result resolution |

## Verification
Every result of this block is one register stage from its cause:
- A write lands at the edge that samples it, and `bus_err` for that write is valid after the same edge.
- Read data for an address presented before edge k is valid after edge k, and reflects the contents as they stood before that edge.
- The busy bit is still 1 on the two reads that follow a control write.
- The self-clearing reset bit is 1 only on the first of those reads.

The bench drives inputs on the falling edge and samples `bus_err` one half period after the write edge. It always reads back in a separate cycle after the write, so each expected value is tied to a known edge count.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_CFGB   = 1;
  localparam int unsigned OFS_REFSEL = 2;
  localparam int unsigned OFS_EVSEL  = 3;
  localparam int unsigned OFS_FLAGS  = 4;
  localparam int unsigned OFS_DBG    = 5;
  localparam int unsigned OFS_CAL_LO = 6;
  localparam int unsigned OFS_CAL_HI = 7;

  localparam int unsigned CTRL_RST_BIT  = 0;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned CTRL_BUSY_BIT = 7;

  typedef enum logic [1:0] {
    RES_12 = 2'd0,
    RES_16 = 2'd1,
    RES_10 = 2'd2,
    RES_8  = 2'd3
  } res_e;
endpackage

// File: rtl/ctl_access_gate.sv
module ctl_access_gate
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wlock,
  input  logic              dbg,
  input  logic              en_state,
  output logic              wr_ok,
  output logic              refused
);
  logic ext_hit, en_hit, cfg_addr;

  always_comb begin
    cfg_addr = (addr == ADDR_W'(OFS_CFGB))   || (addr == ADDR_W'(OFS_REFSEL)) ||
               (addr == ADDR_W'(OFS_EVSEL))  || (addr == ADDR_W'(OFS_CAL_LO)) ||
               (addr == ADDR_W'(OFS_CAL_HI));
    ext_hit  = wlock && !dbg && (addr != ADDR_W'(OFS_FLAGS));
    en_hit   = en_state && cfg_addr;
    refused  = we && (ext_hit || en_hit);
    wr_ok    = we && !(ext_hit || en_hit);
  end
endmodule

// File: rtl/ctl_flag_reg.sv
module ctl_flag_reg #(
  parameter int unsigned NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_q
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_sync_busy.sv
module ctl_sync_busy #(
  parameter int unsigned BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (trig)        cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NFLAG    = 3,
  parameter int unsigned BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              wlock,
  input  logic              dbg_access,
  input  logic [NFLAG-1:0]  evt_set,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              enabled,
  output logic [1:0]        res_mode
);
  localparam int unsigned FPAD = DATA_W - NFLAG;

  logic              enable_q, swrst_q;
  logic [DATA_W-1:0] cfgb_q, refsel_q, evsel_q, dbgctrl_q, cal_lo_q, cal_hi_q;
  logic [NFLAG-1:0]  intflag_q, flag_clr;
  logic              wr_ok, refused, sync_busy;
  logic              ctrl_wr, sw_reset;

  ctl_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .we(bus_we), .addr(bus_addr), .wlock(wlock), .dbg(dbg_access),
    .en_state(enable_q), .wr_ok(wr_ok), .refused(refused)
  );

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    ctrl_wr  = wr_ok && hit(bus_addr, OFS_CTRL);
    sw_reset = ctrl_wr && bus_wdata[CTRL_RST_BIT];
    flag_clr = (wr_ok && hit(bus_addr, OFS_FLAGS)) ? bus_wdata[NFLAG-1:0] : '0;
    if (sw_reset) flag_clr = '1;
  end

  ctl_flag_reg #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(flag_clr), .flag_q(intflag_q)
  );

  ctl_sync_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .trig(ctrl_wr), .busy(sync_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= 1'b0;
      swrst_q   <= 1'b0;
      cfgb_q    <= '0;
      refsel_q  <= '0;
      evsel_q   <= '0;
      dbgctrl_q <= '0;
      cal_lo_q  <= '0;
      cal_hi_q  <= '0;
    end else if (sw_reset) begin
      enable_q  <= 1'b0;
      swrst_q   <= 1'b1;
      cfgb_q    <= '0;
      refsel_q  <= '0;
      evsel_q   <= '0;
      cal_lo_q  <= '0;
      cal_hi_q  <= '0;
    end else begin
      swrst_q <= 1'b0;
      if (wr_ok) begin
        case (bus_addr)
          ADDR_W'(OFS_CTRL):   enable_q  <= bus_wdata[CTRL_EN_BIT];
          ADDR_W'(OFS_CFGB):   cfgb_q    <= bus_wdata;
          ADDR_W'(OFS_REFSEL): refsel_q  <= bus_wdata;
          ADDR_W'(OFS_EVSEL):  evsel_q   <= bus_wdata;
          ADDR_W'(OFS_DBG):    dbgctrl_q <= bus_wdata;
          ADDR_W'(OFS_CAL_LO): cal_lo_q  <= bus_wdata;
          ADDR_W'(OFS_CAL_HI): cal_hi_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  logic [DATA_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_RST_BIT]  = swrst_q;
    ctrl_rd[CTRL_EN_BIT]   = enable_q;
    ctrl_rd[CTRL_BUSY_BIT] = sync_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= refused;
      case (bus_addr)
        ADDR_W'(OFS_CTRL):   bus_rdata <= ctrl_rd;
        ADDR_W'(OFS_CFGB):   bus_rdata <= cfgb_q;
        ADDR_W'(OFS_REFSEL): bus_rdata <= refsel_q;
        ADDR_W'(OFS_EVSEL):  bus_rdata <= evsel_q;
        ADDR_W'(OFS_FLAGS):  bus_rdata <= {{FPAD{1'b0}}, intflag_q};
        ADDR_W'(OFS_DBG):    bus_rdata <= dbgctrl_q;
        ADDR_W'(OFS_CAL_LO): bus_rdata <= cal_lo_q;
        ADDR_W'(OFS_CAL_HI): bus_rdata <= cal_hi_q;
        default:             bus_rdata <= '0;
      endcase
    end
  end

  assign enabled  = enable_q;
  assign res_mode = cfgb_q[5:4];
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NFLAG  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wlock,
  input logic              dbg_access,
  input logic [NFLAG-1:0]  evt_set,
  input logic              bus_err,
  input logic              enable_q,
  input logic              swrst_q,
  input logic              sync_busy,
  input logic [DATA_W-1:0] refsel_q,
  input logic [DATA_W-1:0] dbgctrl_q,
  input logic [NFLAG-1:0]  intflag_q
);
  // R2: locked non-debug write to a non-flag offset is refused
  assert_lock_err_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && wlock && !dbg_access && bus_addr != ADDR_W'(OFS_FLAGS)) |=> bus_err);

  // R2: refused write leaves the target unchanged
  assert_lock_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && wlock && !dbg_access && bus_addr == ADDR_W'(OFS_REFSEL)) |=> $stable(refsel_q));

  // R5: configuration writes refused while enabled
  assert_en_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && enable_q && bus_addr == ADDR_W'(OFS_REFSEL)) |=> ($stable(refsel_q) && bus_err));

  // R7: reset bit lasts one cycle, peripheral disabled, debug byte kept
  assert_swrst_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    swrst_q |=> !swrst_q);
  assert_swrst_off_R7: assert property (@(posedge clk) disable iff (rst)
    swrst_q |-> !enable_q);
  assert_swrst_dbg_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(swrst_q) |-> (dbgctrl_q == $past(dbgctrl_q)));

  // R8: a hardware set always lands
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((intflag_q & $past(evt_set)) == $past(evt_set)));

  // R9: busy accompanies the reset pulse
  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(swrst_q) |-> sync_busy);
endmodule

bind ctl_regbank ctl_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .wlock(wlock),
  .dbg_access(dbg_access), .evt_set(evt_set), .bus_err(bus_err),
  .enable_q(enable_q), .swrst_q(swrst_q), .sync_busy(sync_busy),
  .refsel_q(refsel_q), .dbgctrl_q(dbgctrl_q), .intflag_q(intflag_q)
);

// File: tb/sim_ctl_regbank.sv
`timescale 1ns/1ps
module sim_ctl_regbank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0, wlock = 1'b0, dbg_access = 1'b0;
  logic [2:0] evt_set = '0;
  logic [7:0] bus_rdata;
  logic       bus_err, enabled;
  logic [1:0] res_mode;

  int nchk = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk;

  ctl_regbank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .wlock(wlock), .dbg_access(dbg_access), .evt_set(evt_set), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .enabled(enabled), .res_mode(res_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // write at one edge, sample bus_err half a period later
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic lk, input logic dbg,
                    input logic exp_err, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; wlock = lk; dbg_access = dbg;
    @(negedge clk);
    bus_we = 1'b0; wlock = 1'b0; dbg_access = 1'b0;
    check(tag, int'(bus_err), int'(exp_err));
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    check(tag, int'(bus_rdata), int'(exp));
  endtask

  // {addr, wdata, wlock, dbg, exp_err, exp_read}
  localparam logic [22:0] VEC [0:13] = '{
    {4'h1, 8'h30, 1'b0, 1'b0, 1'b0, 8'h30},  // R11 CFGB write
    {4'h2, 8'h5A, 1'b1, 1'b0, 1'b1, 8'h00},  // R2 locked
    {4'h2, 8'h5A, 1'b1, 1'b1, 1'b0, 8'h5A},  // R4 debugger bypass
    {4'h5, 8'h01, 1'b0, 1'b0, 1'b0, 8'h01},
    {4'h6, 8'h34, 1'b0, 1'b0, 1'b0, 8'h34},
    {4'h7, 8'h12, 1'b0, 1'b0, 1'b0, 8'h12},
    {4'h3, 8'h0F, 1'b0, 1'b0, 1'b0, 8'h0F},
    {4'h0, 8'h02, 1'b0, 1'b0, 1'b0, 8'h82},  // R6 enable, busy set
    {4'h1, 8'h10, 1'b0, 1'b0, 1'b1, 8'h30},  // R5 refused
    {4'h6, 8'hFF, 1'b0, 1'b0, 1'b1, 8'h34},  // R5 refused
    {4'h5, 8'h03, 1'b0, 1'b0, 1'b0, 8'h03},  // R5 debug byte still open
    {4'hC, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00},  // R10 unmapped
    {4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h80},  // R6 disable
    {4'h1, 8'h20, 1'b0, 1'b0, 1'b0, 8'h20}   // R5 open again
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 bus_err", int'(bus_err), 0);
    check("R1 enabled", int'(enabled), 0);
    check("R1 res_mode", int'(res_mode), 0);
    for (int a = 0; a < 8; a++) rd(4'(a), 8'h00, "R1 reset read");

    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][22:19], VEC[i][18:11], VEC[i][10], VEC[i][9], VEC[i][8], "R2/R4/R5 err");
      rd(VEC[i][22:19], VEC[i][7:0], "R2/R4/R5/R6/R10 read");
    end
    check("R11 res_mode 10-bit", int'(res_mode), 2);

    // R9 busy decay
    wr(4'h0, 8'h02, 1'b0, 1'b0, 1'b0, "R9 err");
    check("R6 enabled", int'(enabled), 1);
    rd(4'h0, 8'h82, "R9 busy 1st");
    rd(4'h0, 8'h82, "R9 busy 2nd");
    rd(4'h0, 8'h02, "R9 busy gone");

    // R7 software reset with enable also set
    wr(4'h0, 8'h03, 1'b0, 1'b0, 1'b0, "R7 err");
    check("R7 enabled", int'(enabled), 0);
    rd(4'h0, 8'h81, "R7 reset bit set");
    rd(4'h0, 8'h80, "R7 reset bit clear");
    rd(4'h1, 8'h00, "R7 CFGB cleared");
    rd(4'h2, 8'h00, "R7 REFSEL cleared");
    rd(4'h6, 8'h00, "R7 cal cleared");
    rd(4'h5, 8'h03, "R7 debug kept");
    check("R7 res_mode", int'(res_mode), 0);

    // R8 / R3 flags
    @(negedge clk); evt_set = 3'b101;
    @(negedge clk); evt_set = 3'b000;
    rd(4'h4, 8'h05, "R8 flags set");
    wr(4'h4, 8'h01, 1'b1, 1'b0, 1'b0, "R3 no err under lock");
    rd(4'h4, 8'h04, "R3 clear under lock");
    @(negedge clk);
    bus_addr = 4'h4; bus_wdata = 8'h04; bus_we = 1'b1; evt_set = 3'b100;
    @(negedge clk);
    bus_we = 1'b0; evt_set = 3'b000;
    rd(4'h4, 8'h04, "R8 set wins");
    wr(4'h4, 8'h04, 1'b0, 1'b0, 1'b0, "R8 err");
    rd(4'h4, 8'h00, "R8 cleared");

    // R2 lock on control register
    wr(4'h0, 8'h02, 1'b1, 1'b0, 1'b1, "R2 ctrl locked");
    check("R2 still disabled", int'(enabled), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule